// File: doc/BRIEF.md
# ADC Result Register Bank

This block holds the finished 10-bit results that an ADC sequencer produces. Each result lands in one of six pairs of read-only bytes: a high byte and a low byte. Every pair has a ready flag and an overrun flag, and the block has a single end-of-sequence flag that a host can poll in place of an interrupt. The sequencer delivers a one-cycle valid strobe with a channel index and the data. A mode input picks the mapping:
- **Normal mapping:** channel n goes to pair n.
- **Repeat mapping:** successive results of the one fixed channel are spread over pairs 0 to 3 in a rotating order.

The host reads bytes through a combinational byte-wide port. Reads have side effects on the clock edge where the read enable is high. Reading a low byte hands off that pair's result, so it clears the pair's flags. Reading the status byte acknowledges the end-of-sequence flag. To detect overruns reliably, the host reads the high byte first and the low byte second. A low byte that shows overrun 0 and ready 1 then means the pair held one valid result that was never overwritten.

Top module: `adc_result_bank`

## Requirements
- R1: After reset every pair's data, ready flag and overrun flag are 0, the end-of-sequence flag is 0 and the rotation pointer is at pair 0.
- R2: With repeat_mode_i low, a valid result with channel index n (0..5) is stored in pair n.
- R3: With repeat_mode_i high, valid results go to pairs 0, 1, 2, 3 in turn and then wrap to pair 0, whatever the channel index. Pairs 4 and 5 are never written in this mode.
- R4: The rotation pointer returns to pair 0 whenever repeat_mode_i differs from its value in the previous cycle. A result accepted in that cycle goes to pair 0.
- R5: Storing a result sets that pair's ready flag.
- R6: Storing a result into a pair whose ready flag is already set also sets that pair's overrun flag.
- R7: A host read of a low byte clears that pair's ready and overrun flags. A read of a high byte changes no flag.
- R8: Byte map:
  - Address 2n is the high byte of pair n, holding result bits 9:2.
  - Address 2n+1 is the low byte of pair n: result bits 1:0 in bits 7:6, bits 5:2 zero, overrun in bit 1, ready in bit 0.
  - Address 12 is status, with end-of-sequence in bit 0 and other bits zero.
  - Addresses 13 to 15 read as 0.
- R9: seq_done_i sets the end-of-sequence flag on the next edge. The set wins over any clear in the same cycle.
- R10: The end-of-sequence flag is cleared by conv_start_i or by a host read of address 12.
- R11: When a result is stored into a pair in the same cycle as a host read of that pair's low byte, the read returns the old contents. The pair then holds the new data with ready 1 and overrun 0.
- R12: In normal mapping a valid result with channel index 6 or 7 is dropped and changes no pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| res_valid_i | input | 1 | One-cycle strobe: a finished result is present |
| res_chan_i | input | 3 | Channel index of the result |
| res_data_i | input | 10 | Conversion result |
| repeat_mode_i | input | 1 | 1 selects rotating repeat mapping, 0 normal mapping |
| seq_done_i | input | 1 | Conversion sequence has completed |
| conv_start_i | input | 1 | A new conversion has been started |
| rd_en_i | input | 1 | Host read strobe; side effects act on this edge |
| rd_addr_i | input | 4 | Host byte address |
| rd_data_o | output | 8 | Byte at rd_addr_i (combinational) |

## Verification
The bench targets the following corner cases; each comment names the fault it catches.
- Rotation in repeat mode runs past four results. A pointer that fails to wrap, or that spills into pairs 4 and 5, leaves wrong data in pair 0 and disturbs the untouched pairs.
- A mode toggle in the middle of the rotation. A design that forgets to restart at pair 0 writes the next result into pair 3.
- The overrun cases: a double write, a high-byte read that must leave the flags alone, and a write colliding with a low-byte read. A design that lets the read win loses the new result's ready flag, and one that carries the old ready flag into overrun reports a false overrun.
- The end-of-sequence set and clear paths, including both arriving in the same cycle, and out-of-range channel indices in normal mode.

// File: rtl/adc_bank_pkg.sv
package adc_bank_pkg;
  localparam int unsigned RES_W       = 10;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned ADDR_W      = 4;
  localparam int unsigned STATUS_ADDR = 12;

  typedef struct packed {
    logic [RES_W-1:0] data;
    logic             ovr;
    logic             ready;
  } pair_t;
endpackage

// File: rtl/adc_slot_map.sv
module adc_slot_map #(
  parameter int unsigned NumPairs = 6,
  parameter int unsigned RotSlots = 4,
  localparam int unsigned ChW     = $clog2(NumPairs + 2),
  localparam int unsigned PtrW    = (RotSlots > 1) ? $clog2(RotSlots) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [ChW-1:0]      chan_i,
  input  logic                repeat_i,
  output logic [NumPairs-1:0] wr_hit_o,
  output logic [PtrW-1:0]     ptr_o,
  output logic                mode_o
);
  logic            mode_q;
  logic [PtrW-1:0] ptr_q, eff_ptr, ptr_inc;
  logic            mode_chg;

  assign mode_chg = repeat_i != mode_q;
  assign eff_ptr  = mode_chg ? '0 : ptr_q;
  assign ptr_inc  = (eff_ptr == PtrW'(RotSlots - 1)) ? '0 : eff_ptr + 1'b1;

  always_comb begin
    wr_hit_o = '0;
    if (valid_i) begin
      if (repeat_i) begin
        for (int i = 0; i < RotSlots; i++)
          if (eff_ptr == PtrW'(i)) wr_hit_o[i] = 1'b1;
      end else begin
        for (int i = 0; i < NumPairs; i++)
          if ({1'b0, chan_i} == (ChW+1)'(i)) wr_hit_o[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      mode_q <= repeat_i;
      ptr_q  <= (valid_i && repeat_i) ? ptr_inc : eff_ptr;
    end
  end

  assign ptr_o  = ptr_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/adc_result_pair.sv
module adc_result_pair
  import adc_bank_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [RES_W-1:0] data_i,
  input  logic             rd_lo_i,
  output pair_t            pair_o
);
  pair_t pair_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_q <= '0;
    end else if (wr_i) begin
      pair_q.data  <= data_i;
      pair_q.ready <= 1'b1;
      // a same-cycle low read consumed the old result: no overrun
      pair_q.ovr   <= rd_lo_i ? 1'b0 : (pair_q.ovr | pair_q.ready);
    end else if (rd_lo_i) begin
      pair_q.ready <= 1'b0;
      pair_q.ovr   <= 1'b0;
    end
  end

  assign pair_o = pair_q;
endmodule

// File: rtl/adc_eos_flag.sv
module adc_eos_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic start_i,
  input  logic ack_i,
  output logic eos_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                eos_o <= 1'b0;
    else if (set_i)             eos_o <= 1'b1;
    else if (start_i || ack_i)  eos_o <= 1'b0;
  end
endmodule

// File: rtl/adc_read_port.sv
module adc_read_port
  import adc_bank_pkg::*;
#(
  parameter int unsigned NumPairs = 6
) (
  input  logic                    rd_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  pair_t [NumPairs-1:0]    pairs_i,
  input  logic                    eos_i,
  output logic [BYTE_W-1:0]       data_o,
  output logic [NumPairs-1:0]     rd_lo_o,
  output logic                    stat_rd_o
);
  logic [NumPairs-1:0][BYTE_W-1:0] hi_b, lo_b;

  for (genvar g = 0; g < NumPairs; g++) begin : g_bytes
    assign hi_b[g]    = pairs_i[g].data[RES_W-1 -: BYTE_W];
    assign lo_b[g]    = {pairs_i[g].data[RES_W-BYTE_W-1:0], 4'b0000,
                         pairs_i[g].ovr, pairs_i[g].ready};
    assign rd_lo_o[g] = rd_en_i && (addr_i == ADDR_W'(2*g + 1));
  end

  assign stat_rd_o = rd_en_i && (addr_i == ADDR_W'(STATUS_ADDR));

  always_comb begin
    data_o = '0;
    for (int i = 0; i < NumPairs; i++) begin
      if (addr_i == ADDR_W'(2*i))     data_o = hi_b[i];
      if (addr_i == ADDR_W'(2*i + 1)) data_o = lo_b[i];
    end
    if (addr_i == ADDR_W'(STATUS_ADDR)) data_o = {{(BYTE_W-1){1'b0}}, eos_i};
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_bank_pkg::*;
#(
  parameter int unsigned NumPairs = 6,
  parameter int unsigned RotSlots = 4,
  localparam int unsigned ChW     = $clog2(NumPairs + 2),
  localparam int unsigned PtrW    = (RotSlots > 1) ? $clog2(RotSlots) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_valid_i,
  input  logic [ChW-1:0]    res_chan_i,
  input  logic [RES_W-1:0]  res_data_i,
  input  logic              repeat_mode_i,
  input  logic              seq_done_i,
  input  logic              conv_start_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [NumPairs-1:0] wr_hit, rd_lo_vec, ready_vec, ovr_vec;
  logic [PtrW-1:0]     slot_ptr;
  logic                mode_q, stat_rd, eos_q;
  pair_t [NumPairs-1:0] pairs;

  adc_slot_map #(.NumPairs(NumPairs), .RotSlots(RotSlots)) i_map (
    .clk_i, .rst_ni,
    .valid_i  (res_valid_i),
    .chan_i   (res_chan_i),
    .repeat_i (repeat_mode_i),
    .wr_hit_o (wr_hit),
    .ptr_o    (slot_ptr),
    .mode_o   (mode_q)
  );

  for (genvar g = 0; g < NumPairs; g++) begin : g_pair
    adc_result_pair i_pair (
      .clk_i, .rst_ni,
      .wr_i    (wr_hit[g]),
      .data_i  (res_data_i),
      .rd_lo_i (rd_lo_vec[g]),
      .pair_o  (pairs[g])
    );
    assign ready_vec[g] = pairs[g].ready;
    assign ovr_vec[g]   = pairs[g].ovr;
  end

  adc_eos_flag i_eos (
    .clk_i, .rst_ni,
    .set_i   (seq_done_i),
    .start_i (conv_start_i),
    .ack_i   (stat_rd),
    .eos_o   (eos_q)
  );

  adc_read_port #(.NumPairs(NumPairs)) i_rd (
    .rd_en_i,
    .addr_i    (rd_addr_i),
    .pairs_i   (pairs),
    .eos_i     (eos_q),
    .data_o    (rd_data_o),
    .rd_lo_o   (rd_lo_vec),
    .stat_rd_o (stat_rd)
  );
endmodule

// File: rtl/adc_result_bank_chk.sv
module adc_result_bank_chk #(
  parameter int unsigned NumPairs = 6,
  parameter int unsigned RotSlots = 4,
  parameter int unsigned PtrW     = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                res_valid_i,
  input logic                repeat_mode_i,
  input logic                seq_done_i,
  input logic                conv_start_i,
  input logic [NumPairs-1:0] wr_hit,
  input logic [NumPairs-1:0] rd_lo_vec,
  input logic [NumPairs-1:0] ready_vec,
  input logic [NumPairs-1:0] ovr_vec,
  input logic [PtrW-1:0]     slot_ptr,
  input logic                mode_q,
  input logic                eos_q
);
  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_hit)); // R2
  AST_REPEAT_LOW_PAIRS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repeat_mode_i |-> (wr_hit >> RotSlots) == '0); // R3
  AST_PTR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && repeat_mode_i && (repeat_mode_i == mode_q)
    |=> slot_ptr == PtrW'((32'($past(slot_ptr)) + 1) % RotSlots)); // R3
  AST_PTR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (repeat_mode_i != mode_q) && !res_valid_i |=> slot_ptr == '0); // R4
  AST_READY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit != '0 |=> (ready_vec & $past(wr_hit)) == $past(wr_hit)); // R5
  AST_OVR_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_vec & ~ready_vec) == '0); // R6
  AST_LOW_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lo_vec & ~wr_hit) != '0 |=> (ready_vec & $past(rd_lo_vec & ~wr_hit)) == '0); // R7
  AST_EOS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_i |=> eos_q); // R9
  AST_EOS_START_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_i && !seq_done_i |=> !eos_q); // R10
endmodule

bind adc_result_bank adc_result_bank_chk #(
  .NumPairs(NumPairs), .RotSlots(RotSlots), .PtrW(PtrW)
) i_chk (
  .clk_i, .rst_ni, .res_valid_i, .repeat_mode_i, .seq_done_i, .conv_start_i,
  .wr_hit, .rd_lo_vec, .ready_vec, .ovr_vec, .slot_ptr, .mode_q, .eos_q
);

// File: tb/test_adc_result_bank.sv
module test_adc_result_bank;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       res_valid_i = 1'b0;
  logic [2:0] res_chan_i = '0;
  logic [9:0] res_data_i = '0;
  logic       repeat_mode_i = 1'b0;
  logic       seq_done_i = 1'b0;
  logic       conv_start_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [3:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;

  int n_run = 0;
  int n_fail = 0;
  logic [9:0] norm_d [6];

  always #4 clk_i = ~clk_i;

  adc_result_bank i_adc_result_bank (.*);

  function automatic logic [7:0] lo_b(logic [9:0] d, logic ovr, logic rdy);
    return {d[1:0], 4'b0000, ovr, rdy};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp_v);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp_v);
    end
  endtask

  task automatic wr(logic [2:0] ch, logic [9:0] d);
    @(negedge clk_i);
    res_valid_i = 1'b1; res_chan_i = ch; res_data_i = d;
    @(negedge clk_i);
    res_valid_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; rd_addr_i = a;
    #1 d = rd_data_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic pulse_mode(logic m);
    @(negedge clk_i);
    repeat_mode_i = m;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      check("R1 reset byte", d, 8'h00);
    end
  endtask

  task automatic t_normal();
    logic [7:0] d;
    for (int n = 0; n < 6; n++) begin
      norm_d[n] = 10'(n * 157 + 13);
      wr(3'(n), norm_d[n]);
    end
    for (int n = 0; n < 6; n++) begin
      rd(4'(2*n), d);
      check("R2/R8 high byte", d, norm_d[n][9:2]);
      rd(4'(2*n), d);
      check("R7 high read keeps flags", d, norm_d[n][9:2]);
      rd(4'(2*n+1), d);
      check("R5/R8 low byte ready", d, lo_b(norm_d[n], 1'b0, 1'b1));
      rd(4'(2*n+1), d);
      check("R7 low read clears", d, lo_b(norm_d[n], 1'b0, 1'b0));
    end
    for (int a = 13; a < 16; a++) begin
      rd(4'(a), d);
      check("R8 unmapped", d, 8'h00);
    end
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    wr(3'd2, 10'h155);
    wr(3'd2, 10'h2AA);
    rd(4'd4, d);
    check("R6 high byte newest", d, 8'hAA);
    rd(4'd5, d);
    check("R6 overrun set", d, lo_b(10'h2AA, 1'b1, 1'b1));
    rd(4'd5, d);
    check("R7 overrun cleared", d, lo_b(10'h2AA, 1'b0, 1'b0));
  endtask

  task automatic t_repeat();
    logic [7:0] d;
    logic [9:0] v [6];
    pulse_mode(1'b1);
    for (int k = 0; k < 6; k++) begin
      v[k] = 10'(k * 91 + 40);
      wr(3'd3, v[k]);
    end
    rd(4'd1, d); check("R3 pair0 wrapped", d, lo_b(v[4], 1'b1, 1'b1));
    rd(4'd3, d); check("R3 pair1 wrapped", d, lo_b(v[5], 1'b1, 1'b1));
    rd(4'd5, d); check("R3 pair2", d, lo_b(v[2], 1'b0, 1'b1));
    rd(4'd7, d); check("R3 pair3", d, lo_b(v[3], 1'b0, 1'b1));
    rd(4'd9, d); check("R3 pair4 untouched", d, lo_b(norm_d[4], 1'b0, 1'b0));
    rd(4'd11, d); check("R3 pair5 untouched", d, lo_b(norm_d[5], 1'b0, 1'b0));
    rd(4'd0, d); check("R3 pair0 high", d, v[4][9:2]);
  endtask

  task automatic t_mode_change();
    logic [7:0] d;
    wr(3'd0, 10'h0C1);          // pointer at 2 -> pair2
    pulse_mode(1'b0);
    pulse_mode(1'b1);
    wr(3'd0, 10'h3F2);          // must land in pair0
    rd(4'd1, d); check("R4 restart at pair0", d, lo_b(10'h3F2, 1'b0, 1'b1));
    rd(4'd7, d); check("R4 pair3 not written", d[1:0], 2'b00);
    rd(4'd5, d); check("R4 pair2 got prior", d, lo_b(10'h0C1, 1'b0, 1'b1));
    pulse_mode(1'b0);
  endtask

  task automatic t_eos();
    logic [7:0] d;
    @(negedge clk_i); seq_done_i = 1'b1;
    @(negedge clk_i); seq_done_i = 1'b0;
    rd(4'd12, d); check("R9 eos set", d, 8'h01);
    rd(4'd12, d); check("R10 eos cleared by status read", d, 8'h00);
    @(negedge clk_i); seq_done_i = 1'b1;
    @(negedge clk_i); seq_done_i = 1'b0; conv_start_i = 1'b1;
    @(negedge clk_i); conv_start_i = 1'b0;
    rd(4'd12, d); check("R10 eos cleared by start", d, 8'h00);
    @(negedge clk_i); seq_done_i = 1'b1; conv_start_i = 1'b1;
    @(negedge clk_i); seq_done_i = 1'b0; conv_start_i = 1'b0;
    rd(4'd12, d); check("R9 set wins over start", d, 8'h01);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    wr(3'd1, 10'h1E7);
    @(negedge clk_i);
    res_valid_i = 1'b1; res_chan_i = 3'd1; res_data_i = 10'h302;
    rd_en_i = 1'b1; rd_addr_i = 4'd3;
    #1 d = rd_data_o;
    @(negedge clk_i);
    res_valid_i = 1'b0; rd_en_i = 1'b0;
    check("R11 read returns old", d, lo_b(10'h1E7, 1'b0, 1'b1));
    rd(4'd3, d); check("R11 write wins, no overrun", d, lo_b(10'h302, 1'b0, 1'b1));
    rd(4'd2, d); check("R11 new high byte", d, 8'hC0);
  endtask

  task automatic t_bad_chan();
    logic [7:0] d;
    wr(3'd6, 10'h3FF);
    wr(3'd7, 10'h3FF);
    for (int n = 0; n < 6; n++) begin
      rd(4'(2*n+1), d);
      check("R12 bad channel ignored", {6'd0, d[1:0]}, 8'h00);
    end
    rd(4'd8, d); check("R12 pair4 high intact", d, norm_d[4][9:2]);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_normal();
    t_overrun();
    t_repeat();
    t_mode_change();
    t_eos();
    t_collision();
    t_bad_chan();
    repeat (2) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule